// File: doc/BRIEF.md
# Half-Unit Coin Vending Controller

This block runs the purchase logic of a single-product drink vending point where the item costs 2.5 currency units and only 0.5 and 1.0 unit coins are taken. Each coin reaches the block as a one-cycle strobe with a 2-bit code. The controller keeps the credit inserted so far in half-unit steps. When a coin brings the credit to the price or beyond, it pulses a dispense output, reports the change owed and starts again from zero credit.

The credit is held one-hot. Both outputs are Mealy decisions, based on the credit and the coin of the same cycle, and are then registered. They therefore appear on the clock edge that follows the coin which completes the purchase. The price is a parameter counted in half units. At the default value of five halves, the only case that produces change is a 1.0 coin arriving at a credit of 2.0.

Top module: `halfunit_vend_ctrl`

## Requirements
- R1: After reset is released, dispense_o and change_o read 0 and the credit is zero. Five 0.5 coins are then needed before the first dispense.
- R2: While coin_valid_i is high, coin code 2'b01 adds one half unit (0.5) to the credit and code 2'b10 adds two half units (1.0). A coin that leaves the credit below the price produces no dispense.
- R3: A cycle with coin_valid_i low, or with code 2'b00 or 2'b11, leaves the credit unchanged and produces no dispense.
- R4: When the credit plus the current coin reaches the price of 5 half units, dispense_o is 1 in the cycle right after that coin's clock edge.
- R5: On a dispense, change_o equals credit plus coin minus 5, counted in half units. It is 1 only when a 2'b10 coin arrives at a credit of 4 half units, and 0 on every other purchase.
- R6: The credit returns to zero on the same edge that registers a dispense, so the next coin starts a new transaction.
- R7: dispense_o and change_o are single-cycle pulses. Both read 0 in every cycle that does not follow a purchase-completing coin.
- R8: Raising rst clears dispense_o, change_o and the credit at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| coin_valid_i | input | 1 | Coin strobe, one cycle per coin |
| coin_code_i | input | 2 | Coin code: 01 = 0.5, 10 = 1.0, others = no coin |
| dispense_o | output | 1 | Registered one-cycle dispense pulse |
| change_o | output | 2 | Registered change owed, in half units |

## Verification
Every credit level hides behind outputs that stay at zero until a purchase happens. The bench therefore makes each one observable: it feeds 0.5 coins and counts how many are needed to reach the next dispense. The sweep sets up each of the five credit levels from zero, applies every combination of valid and code, and then drains the credit in this way. The one change-producing case, a 1.0 coin at 2.0, is also reached by a run of three whole coins. An asynchronous reset is raised in the middle of a dispense pulse, and again in the middle of a transaction, to show that the clear needs no clock edge.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [1:0] {
        COIN_NONE  = 2'b00,
        COIN_HALF  = 2'b01,
        COIN_WHOLE = 2'b10,
        COIN_BAD   = 2'b11
    } coin_code_e;

    localparam int HALVES_PER_HALF  = 1;
    localparam int HALVES_PER_WHOLE = 2;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode #(
    parameter int VAL_W = 2
) (
    input  logic             valid_i,
    input  logic [1:0]       code_i,
    output logic [VAL_W-1:0] halves_o
);
    import vend_pkg::*;

    always_comb begin
        halves_o = '0;
        if (valid_i) begin
            case (code_i)
                COIN_HALF:  halves_o = VAL_W'(HALVES_PER_HALF);
                COIN_WHOLE: halves_o = VAL_W'(HALVES_PER_WHOLE);
                default:    halves_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/vend_credit_core.sv
module vend_credit_core #(
    parameter int PRICE_HALVES = 5,
    parameter int VAL_W        = 2,
    parameter int CHANGE_W     = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [VAL_W-1:0]        coin_halves_i,
    output logic [PRICE_HALVES-1:0] state_q,
    output logic                    buy_o,
    output logic [CHANGE_W-1:0]     change_o
);
    localparam int STATE_W = PRICE_HALVES;
    localparam int IDX_W   = (PRICE_HALVES > 1) ? $clog2(PRICE_HALVES) : 1;
    localparam int SUM_W   = $clog2(PRICE_HALVES + (1 << VAL_W));
    localparam logic [STATE_W-1:0] ZERO_CREDIT = STATE_W'(1);

    typedef struct packed {
        logic [STATE_W-1:0]  state;
        logic                buy;
        logic [CHANGE_W-1:0] change;
    } core_next_t;

    core_next_t          nx_d;
    logic [IDX_W-1:0]    idx;
    logic                legal;
    logic [SUM_W-1:0]    sum;

    always_comb begin
        idx = '0;
        for (int i = 0; i < STATE_W; i++) begin
            if (state_q[i]) idx = idx | IDX_W'(i);
        end
        legal = ($countones(state_q) == 1);
        sum   = SUM_W'(idx) + SUM_W'(coin_halves_i);

        nx_d.state  = state_q;
        nx_d.buy    = 1'b0;
        nx_d.change = '0;
        if (!legal) begin
            nx_d.state = ZERO_CREDIT;
        end else if (coin_halves_i != '0) begin
            if (sum >= SUM_W'(PRICE_HALVES)) begin
                nx_d.buy    = 1'b1;
                nx_d.change = CHANGE_W'(sum - SUM_W'(PRICE_HALVES));
                nx_d.state  = ZERO_CREDIT;
            end else begin
                nx_d.state = ZERO_CREDIT << sum;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ZERO_CREDIT;
        else     state_q <= nx_d.state;
    end

    assign buy_o    = nx_d.buy;
    assign change_o = nx_d.change;

endmodule

// File: rtl/vend_out_reg.sv
module vend_out_reg #(
    parameter int CHANGE_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                buy_i,
    input  logic [CHANGE_W-1:0] change_i,
    output logic                dispense_q,
    output logic [CHANGE_W-1:0] change_q
);
    typedef struct packed {
        logic                dispense;
        logic [CHANGE_W-1:0] change;
    } out_t;

    out_t out_d;

    always_comb begin
        out_d.dispense = buy_i;
        out_d.change   = buy_i ? change_i : '0;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dispense_q <= 1'b0;
            change_q   <= '0;
        end else begin
            dispense_q <= out_d.dispense;
            change_q   <= out_d.change;
        end
    end

endmodule

// File: rtl/halfunit_vend_ctrl.sv
module halfunit_vend_ctrl #(
    parameter int PRICE_HALVES = 5,
    parameter int CHANGE_W     = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coin_valid_i,
    input  logic [1:0]          coin_code_i,
    output logic                dispense_o,
    output logic [CHANGE_W-1:0] change_o
);
    localparam int VAL_W = 2;

    logic [VAL_W-1:0]        coin_halves;
    logic [PRICE_HALVES-1:0] credit_state;
    logic                    buy_c;
    logic [CHANGE_W-1:0]     change_c;

    vend_coin_decode #(.VAL_W(VAL_W)) u_decode (
        .valid_i  (coin_valid_i),
        .code_i   (coin_code_i),
        .halves_o (coin_halves)
    );

    vend_credit_core #(
        .PRICE_HALVES (PRICE_HALVES),
        .VAL_W        (VAL_W),
        .CHANGE_W     (CHANGE_W)
    ) u_core (
        .clk           (clk),
        .rst           (rst),
        .coin_halves_i (coin_halves),
        .state_q       (credit_state),
        .buy_o         (buy_c),
        .change_o      (change_c)
    );

    vend_out_reg #(.CHANGE_W(CHANGE_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .buy_i      (buy_c),
        .change_i   (change_c),
        .dispense_q (dispense_o),
        .change_q   (change_o)
    );

endmodule

// File: rtl/vend_checks.sv
module vend_checks #(
    parameter int PRICE_HALVES = 5,
    parameter int CHANGE_W     = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    coin_valid_i,
    input logic [1:0]              coin_code_i,
    input logic                    dispense_o,
    input logic [CHANGE_W-1:0]     change_o,
    input logic [PRICE_HALVES-1:0] credit_state
);

    // R4
    dispense_cause_chk: assert property (@(posedge clk) disable iff (rst)
        dispense_o |-> ($past(coin_valid_i) &&
                        ($past(coin_code_i) == 2'b01 || $past(coin_code_i) == 2'b10)));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(coin_valid_i) |-> (!dispense_o && change_o == '0));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dispense_o |=> !dispense_o);

    // R5
    change_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (change_o != '0) |-> dispense_o);

    // R5
    change_max_chk: assert property (@(posedge clk) disable iff (rst)
        change_o <= CHANGE_W'(1));

    // R6
    credit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(credit_state) == 1);

    // R6
    zero_after_buy_chk: assert property (@(posedge clk) disable iff (rst)
        dispense_o |-> credit_state[0]);

endmodule

bind halfunit_vend_ctrl vend_checks #(
    .PRICE_HALVES (PRICE_HALVES),
    .CHANGE_W     (CHANGE_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .coin_valid_i (coin_valid_i),
    .coin_code_i  (coin_code_i),
    .dispense_o   (dispense_o),
    .change_o     (change_o),
    .credit_state (credit_state)
);

// File: tb/halfunit_vend_ctrl_test.sv
module halfunit_vend_ctrl_test;
    localparam int PRICE = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_valid = 1'b0;
    logic [1:0] coin_code = 2'b00;
    logic       dispense;
    logic [1:0] change;

    int checks = 0;
    int errors = 0;
    int cr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    halfunit_vend_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .coin_valid_i (coin_valid),
        .coin_code_i  (coin_code),
        .dispense_o   (dispense),
        .change_o     (change)
    );

    task automatic check(input string tag, input int ed, input int ec);
        checks++;
        if (int'(dispense) != ed || int'(change) != ec) begin
            errors++;
            $display("FAIL %s dispense=%0d change=%0d expected dispense=%0d change=%0d",
                     tag, dispense, change, ed, ec);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] code, input string force_tag);
        int add;
        int sum;
        int ed;
        int ec;
        string tag;
        add = v ? ((code == 2'b01) ? 1 : ((code == 2'b10) ? 2 : 0)) : 0;
        sum = cr + add;
        if (sum >= PRICE) begin
            ed = 1; ec = sum - PRICE; cr = 0;
            tag = (ec != 0) ? "R5" : "R4";
        end else begin
            ed = 0; ec = 0; cr = sum;
            tag = (add == 0) ? "R3" : "R2";
        end
        if (force_tag != "") tag = force_tag;
        coin_valid = v;
        coin_code  = code;
        @(posedge clk);
        @(negedge clk);
        coin_valid = 1'b0;
        coin_code  = 2'b00;
        check(tag, ed, ec);
    endtask

    task automatic drain();
        while (cr != 0) step(1'b1, 2'b01, "");
    endtask

    task automatic fill(input int c);
        drain();
        for (int k = 0; k < c; k++) step(1'b1, 2'b01, "");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 0, 0);
        // R1: five halves from reset, dispense only on the fifth
        for (int k = 0; k < 5; k++) step(1'b1, 2'b01, "R1");

        // Sweep: every credit level x valid x code, then drain to expose credit
        for (int c = 0; c < PRICE; c++) begin
            for (int v = 0; v < 2; v++) begin
                for (int code = 0; code < 4; code++) begin
                    fill(c);
                    step(v[0], code[1:0], "");
                    if (cr == 0 && c != 0) begin
                        // R7: outputs fall back to zero right after the pulse
                        step(1'b0, 2'b00, "R7");
                    end
                    drain();
                end
            end
        end

        // R5 / R6: three whole coins give change, credit restarts at zero
        step(1'b1, 2'b10, "");
        step(1'b1, 2'b10, "");
        step(1'b1, 2'b10, "R5");
        step(1'b1, 2'b10, "R6");
        step(1'b1, 2'b10, "R6");
        step(1'b1, 2'b01, "R6");
        step(1'b0, 2'b01, "R7");

        // Gaps between coins do not disturb the credit
        step(1'b1, 2'b01, "");
        step(1'b0, 2'b10, "R3");
        step(1'b1, 2'b11, "R3");
        step(1'b1, 2'b00, "R3");
        step(1'b1, 2'b10, "");
        step(1'b1, 2'b10, "R4");

        // R8: reset raised during a dispense pulse clears it without a clock
        step(1'b1, 2'b10, "");
        step(1'b1, 2'b10, "");
        step(1'b1, 2'b10, "R5");
        #2 rst = 1'b1;
        #1 check("R8", 0, 0);
        #2 rst = 1'b0;
        cr = 0;
        @(negedge clk);
        // R8: reset mid-transaction drops the credit
        step(1'b1, 2'b10, "");
        step(1'b1, 2'b01, "");
        #2 rst = 1'b1;
        #3 rst = 1'b0;
        cr = 0;
        @(negedge clk);
        for (int k = 0; k < 5; k++) step(1'b1, 2'b01, "R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule